// File: doc/BRIEF.md
# Neighbour-Combining Event Channel Array

This block holds a row of event channels, eight by default. On every clock, each channel takes one source signal. The source is either one of the producer signals coming into the block or the registered output of any channel, itself included. A select of zero gives a constant zero. The channel can then pass the source through three optional stages:

- an AND with the output of the channel above it;
- an OR with the output of the channel below it;
- an inversion of the final value.

The neighbour indices wrap at both ends of the row. Each channel result goes into a flip-flop, and all neighbour and channel-to-channel terms read those flip-flops. Chained and circular channel configurations therefore never form a combinational loop.

A surrounding event fabric uses the array to build small logic functions from producer events, one clock after the inputs change. Examples are gating one event by another, merging two events, or a delay ring. The array does no edge detection or clock-domain handling. Its inputs are assumed to be stable in the clock domain of the array.

Top module: `evt_chan_array`

## Requirements
- R1: While `rst` is high at a rising clock edge, every bit of `chan_o` is 0 after that edge, whatever the other inputs are.
- R2: A channel whose select field is 0, with no stage enabled, outputs 0 after the next edge.
- R3: A select value s in 1..NPROD picks `prod_i[s-1]`, and the channel shows it on `chan_o` one edge later.
- R4: A select value s in NPROD+1..NPROD+NCH picks the registered output `chan_o[s-NPROD-1]` from before the edge. A channel may pick itself or any other channel.
- R5: A select value above NPROD+NCH behaves exactly as 0.
- R6: With `and_next_i[i]` set, the source is ANDed with `chan_o[(i+1) mod NCH]`, so the last channel uses channel 0.
- R7: With `or_prev_i[i]` set, the value is ORed with `chan_o[(i-1) mod NCH]`, so channel 0 uses the last channel.
- R8: With both stages set, the AND is done first and the OR second: result = (source AND next) OR prev.
- R9: With `invert_i[i]` set, the value after the AND and OR stages is inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| prod_i | input | NPROD (16) | Producer signal vector |
| sel_i | input | NCH*SEL_W (40) | Source select fields. Field i is bits [i*SEL_W +: SEL_W] |
| and_next_i | input | NCH (8) | Per-channel enable for the AND with the next channel |
| or_prev_i | input | NCH (8) | Per-channel enable for the OR with the previous channel |
| invert_i | input | NCH (8) | Per-channel enable for the final inversion |
| chan_o | output | NCH (8) | Registered channel outputs |

## Verification
Producer selection is tried with alternating, nibble and reversed-index patterns. These show whether each select value reaches the right producer bit rather than a neighbouring or mirrored one. A delay ring built from channel-to-channel selects tells a previous-cycle read from a same-cycle read. Wrap-around is tested on the last channel for the AND stage and on channel 0 for the OR stage. The case source=0, next=0, prev=1 separates AND-then-OR from OR-then-AND. Out-of-range selects, inversion combinations and a long run of random configurations are compared against a behavioural model on every clock.

// File: rtl/evt_pkg.sv
package evt_pkg;

    // Per-channel stage enables, applied in field order: AND, then OR, then invert.
    typedef struct packed {
        logic and_next;
        logic or_prev;
        logic invert;
    } comb_cfg_t;

    function automatic int sel_width(input int nprod, input int nch);
        return $clog2(nprod + nch + 1);
    endfunction

    function automatic int next_idx(input int i, input int n);
        return (i == n - 1) ? 0 : i + 1;
    endfunction

    function automatic int prev_idx(input int i, input int n);
        return (i == 0) ? n - 1 : i - 1;
    endfunction

endpackage

// File: rtl/evt_src_mux.sv
module evt_src_mux #(
    parameter int NPROD = 16,
    parameter int NCH   = 8,
    parameter int SEL_W = 5
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [NPROD-1:0] prod,
    input  logic [NCH-1:0]   chan,
    output logic             src
);
    // Decoded select: code 0 and any code with no match leave the source at 0.
    always_comb begin
        src = 1'b0;
        for (int p = 0; p < NPROD; p++) begin
            if (sel == SEL_W'(p + 1)) src = prod[p];
        end
        for (int c = 0; c < NCH; c++) begin
            if (sel == SEL_W'(NPROD + 1 + c)) src = chan[c];
        end
    end
endmodule

// File: rtl/evt_combine.sv
module evt_combine
    import evt_pkg::*;
(
    input  logic      src,
    input  logic      nbr_next,
    input  logic      nbr_prev,
    input  comb_cfg_t cfg,
    output logic      y
);
    logic after_and;
    logic after_or;

    always_comb begin
        after_and = cfg.and_next ? (src & nbr_next) : src;
        after_or  = cfg.or_prev  ? (after_and | nbr_prev) : after_and;
        y         = cfg.invert   ? ~after_or : after_or;
    end
endmodule

// File: rtl/evt_chan_array.sv
module evt_chan_array
    import evt_pkg::*;
#(
    parameter int NPROD = 16,
    parameter int NCH   = 8,
    parameter int SEL_W = sel_width(NPROD, NCH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NPROD-1:0]     prod_i,
    input  logic [NCH*SEL_W-1:0] sel_i,
    input  logic [NCH-1:0]       and_next_i,
    input  logic [NCH-1:0]       or_prev_i,
    input  logic [NCH-1:0]       invert_i,
    output logic [NCH-1:0]       chan_o
);
    localparam int MAX_CODE = NPROD + NCH;

    logic [NCH-1:0] chan_q;
    logic [NCH-1:0] chan_d;

    assign chan_o = chan_q;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam int NX = next_idx(i, NCH);
        localparam int PV = prev_idx(i, NCH);

        logic             src;
        comb_cfg_t        cfg;
        logic [SEL_W-1:0] sel;

        assign sel = sel_i[i*SEL_W +: SEL_W];
        assign cfg = '{and_next: and_next_i[i], or_prev: or_prev_i[i], invert: invert_i[i]};

        evt_src_mux #(.NPROD(NPROD), .NCH(NCH), .SEL_W(SEL_W)) u_mux (
            .sel  (sel),
            .prod (prod_i),
            .chan (chan_q),
            .src  (src)
        );

        evt_combine u_comb (
            .src      (src),
            .nbr_next (chan_q[NX]),
            .nbr_prev (chan_q[PV]),
            .cfg      (cfg),
            .y        (chan_d[i])
        );

        p_off_zero_r2: assert property (@(posedge clk) disable iff (rst)
            (sel == '0 && !and_next_i[i] && !or_prev_i[i] && !invert_i[i]) |=> !chan_o[i]);

        p_range_off_r5: assert property (@(posedge clk) disable iff (rst)
            (int'(sel) > MAX_CODE && !and_next_i[i] && !or_prev_i[i] && !invert_i[i]) |=> !chan_o[i]);

        p_and_next_r6: assert property (@(posedge clk) disable iff (rst)
            (and_next_i[i] && !or_prev_i[i] && !invert_i[i] && !chan_o[NX]) |=> !chan_o[i]);

        p_or_prev_r7: assert property (@(posedge clk) disable iff (rst)
            (or_prev_i[i] && !invert_i[i] && chan_o[PV]) |=> chan_o[i]);

        p_order_r8: assert property (@(posedge clk) disable iff (rst)
            (and_next_i[i] && or_prev_i[i] && !invert_i[i] && !chan_o[NX] && !chan_o[PV]) |=> !chan_o[i]);

        p_invert_r9: assert property (@(posedge clk) disable iff (rst)
            (sel == '0 && !and_next_i[i] && !or_prev_i[i] && invert_i[i]) |=> chan_o[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) chan_q <= '0;
        else     chan_q <= chan_d;
    end

    p_reset_clear_r1: assert property (@(posedge clk) rst |=> chan_o == '0);

endmodule

// File: tb/tb_evt_chan_array.sv
`timescale 1ns/1ps
module tb_evt_chan_array;
    localparam int NPROD = 16;
    localparam int NCH   = 8;
    localparam int SEL_W = $clog2(NPROD + NCH + 1);

    logic                 clk = 1'b0;
    logic                 rst;
    logic [NPROD-1:0]     prod_i;
    logic [NCH*SEL_W-1:0] sel_i;
    logic [NCH-1:0]       and_next_i, or_prev_i, invert_i;
    logic [NCH-1:0]       chan_o;

    int sel_a [NCH];
    bit model_q [NCH];
    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int c = 0; c < NCH; c++) sel_i[c*SEL_W +: SEL_W] = SEL_W'(sel_a[c]);
    end

    evt_chan_array #(.NPROD(NPROD), .NCH(NCH)) dut (
        .clk(clk), .rst(rst), .prod_i(prod_i), .sel_i(sel_i),
        .and_next_i(and_next_i), .or_prev_i(or_prev_i), .invert_i(invert_i),
        .chan_o(chan_o)
    );

    function automatic logic [NCH-1:0] model_bits();
        logic [NCH-1:0] v;
        for (int c = 0; c < NCH; c++) v[c] = model_q[c];
        return v;
    endfunction

    // One clock: compute expected from inputs and previous model state, compare after the edge.
    task automatic step(input string tag);
        bit nxt [NCH];
        logic [NCH-1:0] exp_v;
        for (int c = 0; c < NCH; c++) begin
            bit s;
            bit v;
            int code = sel_a[c];
            if (rst) begin
                nxt[c] = 0;
            end else begin
                if (code >= 1 && code <= NPROD) s = prod_i[code-1];
                else if (code > NPROD && code <= NPROD + NCH) s = model_q[code-NPROD-1];
                else s = 0;
                v = s;
                if (and_next_i[c]) v = v & model_q[(c + 1) % NCH];
                if (or_prev_i[c])  v = v | model_q[(c + NCH - 1) % NCH];
                if (invert_i[c])   v = !v;
                nxt[c] = v;
            end
        end
        @(posedge clk);
        #1;
        for (int c = 0; c < NCH; c++) exp_v[c] = nxt[c];
        checks++;
        if (chan_o !== exp_v) begin
            errors++;
            $display("FAIL %s: chan_o=%b expected=%b at %0t", tag, chan_o, exp_v, $time);
        end
        for (int c = 0; c < NCH; c++) model_q[c] = nxt[c];
        @(negedge clk);
    endtask

    task automatic clear_cfg();
        for (int c = 0; c < NCH; c++) sel_a[c] = 0;
        and_next_i = '0; or_prev_i = '0; invert_i = '0;
    endtask

    task automatic sel_identity();
        for (int c = 0; c < NCH; c++) sel_a[c] = c + 1;
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) model_q[c] = 0;
        clear_cfg();
        prod_i = '0;
        rst = 1'b1;
        @(negedge clk);
        // R1: reset clears all channels even with inputs that would drive ones
        prod_i = '1; sel_identity(); invert_i = '1;
        step("R1");
        step("R1");
        rst = 1'b0;
        clear_cfg();

        // R2: select 0 yields zero with all producers high
        prod_i = '1;
        step("R2");
        step("R2");

        // R3: producer selection with several patterns
        sel_identity();
        prod_i = 16'hA5A5; step("R3");
        prod_i = 16'h5A5A; step("R3");
        prod_i = 16'h0F0F; step("R3");
        for (int c = 0; c < NCH; c++) sel_a[c] = NPROD - c;
        prod_i = 16'h8100; step("R3");
        prod_i = 16'h3C00; step("R3");

        // R4: delay ring through channel-to-channel selects
        clear_cfg();
        sel_a[0] = 1;
        for (int c = 1; c < NCH; c++) sel_a[c] = NPROD + c;
        prod_i = 16'h0001; step("R4");
        prod_i = 16'h0000;
        for (int k = 0; k < NCH + 1; k++) step("R4");
        // R4: channel holding itself
        sel_identity(); prod_i = 16'h0055; step("R4");
        for (int c = 0; c < NCH; c++) sel_a[c] = NPROD + 1 + c;
        prod_i = '0; step("R4"); step("R4");

        // R5: out-of-range codes act as off
        prod_i = '1;
        for (int c = 0; c < NCH; c++) sel_a[c] = NPROD + NCH + 1 + (c % 7);
        step("R5"); step("R5");

        // R6: AND with next, wrap on the last channel
        clear_cfg(); sel_identity(); prod_i = 16'h0001; step("R6");
        clear_cfg(); prod_i = '1; sel_a[NCH-1] = 1; and_next_i[NCH-1] = 1'b1;
        step("R6"); step("R6");

        // R7: OR with previous, wrap on channel 0
        clear_cfg(); sel_identity(); prod_i = 16'h0080; step("R7");
        clear_cfg(); prod_i = '0; or_prev_i[0] = 1'b1;
        step("R7"); step("R7");

        // R8: AND applied before OR: src=0, next=0, prev=1 gives 1
        clear_cfg(); sel_identity(); prod_i = 16'h0080; step("R8");
        clear_cfg(); prod_i = '0; and_next_i[0] = 1'b1; or_prev_i[0] = 1'b1;
        step("R8");
        sel_identity(); prod_i = 16'h0081; step("R8");
        clear_cfg(); prod_i = 16'h00FF; sel_a[3] = 4; and_next_i[3] = 1'b1; or_prev_i[3] = 1'b1;
        step("R8");

        // R9: inversion is last
        clear_cfg(); invert_i = '1; step("R9");
        or_prev_i = '1; step("R9");
        sel_identity(); prod_i = 16'h00F0; and_next_i = '1; or_prev_i = '0; step("R9");

        // Mixed random configurations
        for (int k = 0; k < 400; k++) begin
            prod_i = NPROD'($urandom);
            for (int c = 0; c < NCH; c++) sel_a[c] = $urandom_range(0, (1 << SEL_W) - 1);
            and_next_i = NCH'($urandom);
            or_prev_i  = NCH'($urandom);
            invert_i   = NCH'($urandom);
            step("mixed R3 R4 R6 R7 R8 R9");
        end
        // R1 again mid-run
        rst = 1'b1; step("R1"); rst = 1'b0;
        if (model_bits() !== chan_o) begin
            errors++; checks++;
            $display("FAIL R1: chan_o=%b expected=%b", chan_o, model_bits());
        end else checks++;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule